// File: doc/BRIEF.md
# Oscillator Stability and Power-Down Controller

This block holds the control and status register that sits beside a crystal oscillator and a frequency-multiplying PLL. Software writes the register through a plain write-enable/data port and reads it back through a combinational read bus. Four writable bits drive the PLL enable (bypass versus multiplied clock), the PLL power-down, the PLL reset and an oscillator power-down request. Two read-only bits report whether the oscillator output has settled and whether the PLL has reached phase lock.

Oscillator settling is judged by a reference-cycle counter that must reach `STABLE_CYCLES` (41,032 by default) before the stable bit is raised. A test-mode input or a counter-disable input forces the stable bit high. The oscillator power-down request takes effect either on the next cycle or only while the clock generator reports idle, as selected by a clock-mode input. Every time the oscillator is brought back up the counter starts again. The lock input is asynchronous to the register clock and passes through a two-stage synchronizer.

Top module: `osc_pll_ctl`

## Requirements
- R1: After reset the register reads 0x08: PLL reset (bit 3) is 1, and PLL enable (bit 0), PLL power-down (bit 1), oscillator power-down request (bit 2), lock (bit 5) and stable (bit 6) are 0. Outputs pll_rst_o=1, pll_en_o=0, pll_pd_o=0, osc_pd_o=0.
- R2: With test mode and counter disable low, stable (bit 6) stays 0 until the counter has counted STABLE_CYCLES reference cycles after internal reset release. Internal release comes two clock edges after rst_n rises, so stable first reads 1 after edge STABLE_CYCLES+2.
- R3: Stable (bit 6) reads 1 whenever test_mode_i or stab_cnt_dis_i is 1, even while the oscillator is powered down.
- R4: Lock (bit 5) follows pll_lock_i after exactly two clock edges.
- R5: A write stores wdata bit 0 to PLL enable, bit 1 to PLL power-down, bit 2 to the oscillator power-down request and bit 3 to PLL reset. The stored bits read back at the same positions. pll_en_o, pll_pd_o and pll_rst_o equal the stored bits from the edge that took the write.
- R6: With osc_pd_mode_i=1, osc_pd_o rises on the edge after the one that stores a request of 1.
- R7: With osc_pd_mode_i=0 and a pending request, osc_pd_o stays 0 while gen_idle_i is 0. It rises on the edge after gen_idle_i becomes 1, and falls on the edge after gen_idle_i returns to 0.
- R8: Clearing the request drops osc_pd_o on the next edge. While the oscillator is down the counter is held at zero. After the oscillator comes back up, stable reads 1 only after STABLE_CYCLES more edges.
- R9: Write data in bits 4 to 7 is ignored. Bits 4 and 7 always read 0, and bits 5 and 6 keep reporting status.
- R10: If a power-down takes effect on the same edge that the count would have completed, the power-down wins: the counter restarts and stable stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; also clocks the register |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Write strobe for the register |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data (combinational) |
| pll_lock_i | input | 1 | Asynchronous phase-lock indication from the PLL |
| gen_idle_i | input | 1 | Clock generator idle status |
| osc_pd_mode_i | input | 1 | 1: power-down at once; 0: wait for idle |
| test_mode_i | input | 1 | Forces the stable bit high |
| stab_cnt_dis_i | input | 1 | Disables the settle counter; forces stable high |
| osc_pd_o | output | 1 | Oscillator power-down |
| pll_pd_o | output | 1 | PLL power-down |
| pll_rst_o | output | 1 | PLL reset (active high) |
| pll_en_o | output | 1 | 1: PLL mode, 0: bypass |

## Verification
The settle counter finishing and a power-down request taking effect can land on the same edge. The bench provokes this by clearing the request and counting edges until the counter sits one short of the limit. It then writes a new request so that the power-down lands on the completing edge, and checks that stable stays 0 and osc_pd_o is 1. A second overlap, a software write together with a status change, is judged by sweeping all writable values with junk in the upper bits and confirming that the status bits still report the counter and the synchronized lock.

// File: rtl/clkgen_ctl_pkg.sv
package clkgen_ctl_pkg;

  // Register bit positions (software decodes these)
  localparam int unsigned BIT_PLL_EN  = 0;
  localparam int unsigned BIT_PLL_PD  = 1;
  localparam int unsigned BIT_OSC_PD  = 2;
  localparam int unsigned BIT_PLL_RST = 3;
  localparam int unsigned BIT_LOCK    = 5;
  localparam int unsigned BIT_STABLE  = 6;

  typedef struct packed {
    logic pll_rst;
    logic osc_pd_req;
    logic pll_pd;
    logic pll_en;
  } ctl_bits_t;

  localparam ctl_bits_t CTL_RESET = '{pll_rst: 1'b1, osc_pd_req: 1'b0, pll_pd: 1'b0, pll_en: 1'b0};

endpackage

// File: rtl/clkgen_rst_sync.sv
module clkgen_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/clkgen_lock_sync.sv
module clkgen_lock_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] ff_q;
  logic [STAGES-1:0] ff_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb ff_d = async_i;
    end else begin : g_chain
      always_comb ff_d = {ff_q[STAGES-2:0], async_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ff_q <= '0;
    else        ff_q <= ff_d;
  end

  assign sync_o = ff_q[STAGES-1];

  generate
    if (STAGES == 2) begin : g_chk
      // R4: a rising lock bit must come from the input two edges earlier
      p_lock_delay_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_o) |-> $past(async_i, 2));
    end
  endgenerate
endmodule

// File: rtl/clkgen_stab_cnt.sv
module clkgen_stab_cnt #(
  parameter int unsigned STABLE_CYCLES = 41032
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  output logic done_o
);
  localparam int unsigned CW = $clog2(STABLE_CYCLES + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(STABLE_CYCLES);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;
  logic          at_last;

  assign at_last = (cnt_q == CNT_LAST);

  always_comb begin
    cnt_en = restart_i | ~at_last;
    cnt_d  = cnt_q;
    if (restart_i)     cnt_d = '0;
    else if (!at_last) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done_o = at_last;

  // R8: a restart must leave the counter unfinished on the next cycle
  p_restart_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> !done_o);
endmodule

// File: rtl/clkgen_pd_seq.sv
module clkgen_pd_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic mode_i,
  input  logic idle_i,
  output logic pd_next_o,
  output logic pd_o
);
  logic pd_q;

  always_comb begin
    pd_next_o = req_i & (mode_i | idle_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pd_q <= 1'b0;
    else        pd_q <= pd_next_o;
  end

  assign pd_o = pd_q;

  // R6: immediate mode powers down on the next edge
  p_pd_immediate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && mode_i) |=> pd_o);
  // R7: idle-gated mode keeps the oscillator running while not idle
  p_pd_wait_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_i && !idle_i) |=> !pd_o);
  // R8: withdrawing the request releases the oscillator
  p_pd_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> !pd_o);
endmodule

// File: rtl/osc_pll_ctl.sv
module osc_pll_ctl #(
  parameter int unsigned DW            = 8,
  parameter int unsigned STABLE_CYCLES = 41032,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          pll_lock_i,
  input  logic          gen_idle_i,
  input  logic          osc_pd_mode_i,
  input  logic          test_mode_i,
  input  logic          stab_cnt_dis_i,
  output logic          osc_pd_o,
  output logic          pll_pd_o,
  output logic          pll_rst_o,
  output logic          pll_en_o
);
  import clkgen_ctl_pkg::*;

  logic      rst_i_n;
  ctl_bits_t ctl_q;
  ctl_bits_t ctl_d;
  logic      lock_s;
  logic      pd_next;
  logic      stab_done;
  logic      stable_bit;

  clkgen_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  clkgen_lock_sync #(.STAGES(SYNC_STAGES)) u_lock (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .async_i (pll_lock_i),
    .sync_o  (lock_s)
  );

  clkgen_pd_seq u_pd (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .req_i     (ctl_q.osc_pd_req),
    .mode_i    (osc_pd_mode_i),
    .idle_i    (gen_idle_i),
    .pd_next_o (pd_next),
    .pd_o      (osc_pd_o)
  );

  clkgen_stab_cnt #(.STABLE_CYCLES(STABLE_CYCLES)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .restart_i (pd_next),
    .done_o    (stab_done)
  );

  // Control register next state
  always_comb begin
    ctl_d = ctl_q;
    if (reg_we) begin
      ctl_d.pll_en     = reg_wdata[BIT_PLL_EN];
      ctl_d.pll_pd     = reg_wdata[BIT_PLL_PD];
      ctl_d.osc_pd_req = reg_wdata[BIT_OSC_PD];
      ctl_d.pll_rst    = reg_wdata[BIT_PLL_RST];
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)    ctl_q <= CTL_RESET;
    else if (reg_we) ctl_q <= ctl_d;
  end

  assign stable_bit = stab_done | test_mode_i | stab_cnt_dis_i;

  always_comb begin
    reg_rdata              = '0;
    reg_rdata[BIT_PLL_EN]  = ctl_q.pll_en;
    reg_rdata[BIT_PLL_PD]  = ctl_q.pll_pd;
    reg_rdata[BIT_OSC_PD]  = ctl_q.osc_pd_req;
    reg_rdata[BIT_PLL_RST] = ctl_q.pll_rst;
    reg_rdata[BIT_LOCK]    = lock_s;
    reg_rdata[BIT_STABLE]  = stable_bit;
  end

  assign pll_en_o  = ctl_q.pll_en;
  assign pll_pd_o  = ctl_q.pll_pd;
  assign pll_rst_o = ctl_q.pll_rst;

  // R8: the counter is never finished while the oscillator is down
  p_down_not_settled_r8: assert property (@(posedge clk) disable iff (!rst_i_n)
    osc_pd_o |-> !stab_done);
  // R10: a power-down landing on the completing edge keeps the counter unfinished
  p_pd_wins_r10: assert property (@(posedge clk) disable iff (!rst_i_n)
    $rose(osc_pd_o) |-> !stab_done);
endmodule

// File: tb/tb_osc_pll_ctl.sv
module tb_osc_pll_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int N = 24;

  logic       clk = 1'b0;
  logic       rst_n, reg_we, pll_lock_i, gen_idle_i, osc_pd_mode_i, test_mode_i, stab_cnt_dis_i;
  logic [7:0] reg_wdata, reg_rdata;
  logic       osc_pd_o, pll_pd_o, pll_rst_o, pll_en_o;
  int         checks = 0, failures = 0;
  bit         done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  osc_pll_ctl #(.DW(8), .STABLE_CYCLES(N), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pll_lock_i(pll_lock_i), .gen_idle_i(gen_idle_i), .osc_pd_mode_i(osc_pd_mode_i),
    .test_mode_i(test_mode_i), .stab_cnt_dis_i(stab_cnt_dis_i),
    .osc_pd_o(osc_pd_o), .pll_pd_o(pll_pd_o), .pll_rst_o(pll_rst_o), .pll_en_o(pll_en_o));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic wr(input logic [7:0] d);
    reg_we = 1'b1; reg_wdata = d;
    step();
    reg_we = 1'b0; reg_wdata = 8'h00;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 0; reg_we = 0; reg_wdata = 0; pll_lock_i = 0; gen_idle_i = 0;
    osc_pd_mode_i = 1; test_mode_i = 0; stab_cnt_dis_i = 0;
    repeat (3) step();
    // R1 reset state
    chk("R1 rdata", reg_rdata, 8'h08);
    chk("R1 outputs", {osc_pd_o, pll_pd_o, pll_rst_o, pll_en_o}, 4'b0010);
    rst_n = 1;
    // R2 settle from reset: stable first at edge N+2
    for (int e = 1; e <= N + 2; e++) begin
      step();
      if (e == 2)     chk("R1 rdata after release", reg_rdata, 8'h08);
      if (e == N + 1) chk("R2 stable before count", reg_rdata[6], 1'b0);
      if (e == N + 2) chk("R2 stable at count", reg_rdata[6], 1'b1);
    end
    // R4 lock synchronizer
    pll_lock_i = 1; step();
    chk("R4 lock after one edge", reg_rdata[5], 1'b0);
    step();
    chk("R4 lock after two edges", reg_rdata[5], 1'b1);
    pll_lock_i = 0; step();
    chk("R4 lock held one edge", reg_rdata[5], 1'b1);
    step();
    chk("R4 lock cleared", reg_rdata[5], 1'b0);
    // R6 immediate power-down
    osc_pd_mode_i = 1;
    wr(8'h0C);
    chk("R6 not yet down", osc_pd_o, 1'b0);
    step();
    chk("R6 down next edge", osc_pd_o, 1'b1);
    chk("R8 stable dropped", reg_rdata[6], 1'b0);
    // R3 override sweep while down
    for (int v = 0; v < 4; v++) begin
      test_mode_i = v[0]; stab_cnt_dis_i = v[1];
      #1;
      chk("R3 override", reg_rdata[6], (v != 0) ? 1'b1 : 1'b0);
    end
    test_mode_i = 0; stab_cnt_dis_i = 0;
    // R8 release and restart
    wr(8'h08);
    for (int i = 1; i <= N; i++) begin
      step();
      if (i == 1)     chk("R8 osc up", osc_pd_o, 1'b0);
      if (i == N - 1) chk("R8 stable before recount", reg_rdata[6], 1'b0);
      if (i == N)     chk("R8 stable after recount", reg_rdata[6], 1'b1);
    end
    // R7 idle-gated power-down
    osc_pd_mode_i = 0; gen_idle_i = 0;
    wr(8'h0C);
    for (int i = 0; i < 3; i++) begin
      step();
      chk("R7 waits for idle", osc_pd_o, 1'b0);
    end
    gen_idle_i = 1; step();
    chk("R7 down on idle", osc_pd_o, 1'b1);
    gen_idle_i = 0; step();
    chk("R7 up on wake", osc_pd_o, 1'b0);
    for (int m = 1; m <= N - 1; m++) begin
      step();
      if (m == N - 2) chk("R8 wake recount pending", reg_rdata[6], 1'b0);
      if (m == N - 1) chk("R8 wake recount done", reg_rdata[6], 1'b1);
    end
    // R5 / R9 exhaustive sweep of writable bits with upper junk
    for (int v = 0; v < 16; v++) begin
      logic [3:0] nib;
      nib = 4'(v);
      wr({4'hF, nib});
      chk("R5 readback", reg_rdata[3:0], nib);
      chk("R5 outputs", {pll_rst_o, pll_pd_o, pll_en_o}, {nib[3], nib[1], nib[0]});
      chk("R9 upper bits", {reg_rdata[7], reg_rdata[6], reg_rdata[5], reg_rdata[4]}, 4'b0100);
    end
    // R10 collision: power-down lands on completing edge
    osc_pd_mode_i = 1;
    wr(8'h04); step();
    wr(8'h00);
    for (int i = 1; i <= N - 2; i++) step();
    wr(8'h04);
    step();
    chk("R10 stable stays low", reg_rdata[6], 1'b0);
    chk("R10 osc down", osc_pd_o, 1'b1);
    step();
    chk("R10 stable still low", reg_rdata[6], 1'b0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule